// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block is the control sequencer of a 16-bit processor that moves execution into the privileged mode and back again. It owns the processor status word, the program counter and two stack pointers, one for the privileged (kernel) mode and one for user mode. A software trap instruction, an illegal instruction or a device interrupt all start one uninterruptible entry sequence. The sequence does four things in order:

- it captures the old status word and program counter;
- it reads a fresh PC and status word from a small vector slot in low memory;
- it overwrites the previous-mode field of the fresh status word with the mode that was running;
- it pushes the captured status word and then the captured PC onto the stack that the fresh status word selects.

A return request pops the PC and then the status word from the active stack. Reloading the status word can switch the processor back to user mode, and with it to the user stack.

The surrounding core signals each instruction boundary and the kind of instruction that has just completed. The sequencer accepts events only at such a boundary and only while no sequence is running. A full-word status write from the execute stage lets software raise or lower the priority level that holds off device interrupts. Memory is one word-wide port. A read returns its data in the cycle after the request.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, the status word is RESET_PSW, the PC is RESET_PC, busy is 0 and no memory request is made. With the default 0170000 octal status word, the active stack pointer is the user one.
- R2: A software trap fetches the new PC from byte address 034 octal and the new status word from 036 octal. These values become the PC and the status word.
- R3: After entry, bits 13..12 (previous mode) of the status word hold the bits 15..14 (current mode) that were in effect before the event. All other bits come from the vector slot.
- R4: An entry writes the old status word at active SP−2 and the old PC at SP−4, and leaves SP lowered by 4. The saved PC ends at SP and the saved status word at SP+2.
- R5: The active stack pointer is the user one exactly when status bits 15..14 are 11. Otherwise it is the kernel one. Entry pushes go to the stack selected by the newly loaded status word.
- R6: A device interrupt is taken only when irq_level is strictly greater than status bits 7..5. It then uses irq_vector as its slot address, and irq_ack is high in the accepting cycle.
- R7: When several requests meet at one boundary, the order of precedence is: software trap, then illegal instruction (vector 010 octal), then an eligible interrupt, then return.
- R8: A return reads the PC from the word at SP and the status word from SP+2, and leaves SP raised by 4. The SP that is raised is the one active before the status word is reloaded.
- R9: While a sequence runs (busy high), boundary strobes, event requests and status writes are ignored, and no further sequence starts.
- R10: An entry holds busy for exactly 5 cycles and a return for 3. A boundary with no eligible request starts nothing.
- R11: In an idle cycle without an accepted event, psw_wr_en loads psw_wr_val into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_boundary | input | 1 | The core is between instructions this cycle |
| svc_req | input | 1 | Completed instruction was a software trap |
| ill_req | input | 1 | Completed instruction was illegal |
| irq_req | input | 1 | A device interrupt is pending |
| irq_level | input | 3 | Priority level of the pending interrupt |
| irq_vector | input | VEC_W | Vector slot byte address of the pending interrupt |
| rtt_req | input | 1 | Completed instruction was a return-from-trap |
| psw_wr_en | input | 1 | Status word write from the execute stage |
| psw_wr_val | input | 16 | Value for that write |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address (word aligned) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| busy | output | 1 | A sequence is in progress |
| psw | output | 16 | Current status word |
| pc | output | 16 | Current program counter |
| sp_active | output | 16 | Stack pointer of the current mode |

## Verification
The hardest behaviour to reach from the ports is the atomicity of R9. The block has to ignore a boundary strobe, a top-level interrupt and a status write that all arrive in the middle of an entry, including in the last push cycle, where a careless design would chain a second entry. The bench holds all three high through every busy cycle of a trap. It drops them in the same cycle busy falls, and then checks the ports: exactly one push pair, the vector status word and the vector PC. A sweep over all 64 pairs of interrupt level and status priority covers the strict comparison of R6 at every boundary, and a return after each accepted interrupt restores the state.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_VPC, S_VPSW, S_LDPSW, S_PUSH_PSW, S_PUSH_PC,
    S_POP_PC, S_POP_PSW, S_RLPSW
  } seq_st_t;

  localparam logic [1:0] MODE_USER = 2'b11;

  // Fresh status word from a vector with the previous-mode field replaced.
  function automatic logic [WORD_W-1:0] with_prev(input logic [WORD_W-1:0] fresh,
                                                  input logic [1:0] cur_mode);
    return {fresh[15:14], cur_mode, fresh[11:0]};
  endfunction

  function automatic logic uses_user_sp(input logic [WORD_W-1:0] st_word);
    return st_word[15:14] == MODE_USER;
  endfunction

  function automatic logic irq_beats(input logic [2:0] lvl, input logic [2:0] pri);
    return lvl > pri;
  endfunction
endpackage

// File: rtl/trap_cause_arb.sv
module trap_cause_arb
  import trap_seq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] SVC_VEC = 8'o034,
  parameter logic [VEC_W-1:0] ILL_VEC = 8'o010
) (
  input  logic             boundary,
  input  logic             idle,
  input  logic             svc_req,
  input  logic             ill_req,
  input  logic             irq_req,
  input  logic [2:0]       irq_level,
  input  logic [VEC_W-1:0] irq_vector,
  input  logic             rtt_req,
  input  logic [2:0]       cur_pri,
  output logic             take_entry,
  output logic             take_rtt,
  output logic             irq_ack,
  output logic [VEC_W-1:0] vec_sel
);
  logic gate, irq_ok, any_entry;

  always_comb begin
    gate      = boundary && idle;
    irq_ok    = irq_req && irq_beats(irq_level, cur_pri);
    any_entry = svc_req || ill_req || irq_ok;
    if (svc_req)      vec_sel = SVC_VEC;
    else if (ill_req) vec_sel = ILL_VEC;
    else              vec_sel = irq_vector;
    take_entry = gate && any_entry;
    irq_ack    = gate && irq_ok && !svc_req && !ill_req;
    take_rtt   = gate && rtt_req && !any_entry;
  end
endmodule

// File: rtl/trap_sp_bank.sv
module trap_sp_bank
  import trap_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] KSP_INIT = 16'o000400,
  parameter logic [WORD_W-1:0] USP_INIT = 16'o000700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_user,
  input  logic              step_dn,
  input  logic              step_up,
  output logic [WORD_W-1:0] sp_act
);
  localparam int N_SP = 2;
  logic [WORD_W-1:0] sp_q [N_SP];

  for (genvar i = 0; i < N_SP; i++) begin : g_sp
    localparam logic [WORD_W-1:0] INIT = (i == 1) ? USP_INIT : KSP_INIT;
    always_ff @(posedge clk) begin
      if (!rst_n) sp_q[i] <= INIT;
      else if (sel_user == 1'(i)) begin
        if (step_dn)      sp_q[i] <= sp_q[i] - WORD_W'(2);
        else if (step_up) sp_q[i] <= sp_q[i] + WORD_W'(2);
      end
    end
  end

  assign sp_act = sp_q[sel_user];

  // R4: each push word lowers the active pointer by one word
  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |=> sp_act == $past(sp_act) - WORD_W'(2));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0]  SVC_VEC   = 8'o034,
  parameter logic [VEC_W-1:0]  ILL_VEC   = 8'o010,
  parameter logic [15:0]       RESET_PSW = 16'o170000,
  parameter logic [15:0]       RESET_PC  = 16'o004000,
  parameter logic [15:0]       KSP_INIT  = 16'o000400,
  parameter logic [15:0]       USP_INIT  = 16'o000700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_boundary,
  input  logic             svc_req,
  input  logic             ill_req,
  input  logic             irq_req,
  input  logic [2:0]       irq_level,
  input  logic [VEC_W-1:0] irq_vector,
  input  logic             rtt_req,
  input  logic             psw_wr_en,
  input  logic [15:0]      psw_wr_val,
  output logic             mem_req,
  output logic             mem_we,
  output logic [15:0]      mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  output logic             irq_ack,
  output logic             busy,
  output logic [15:0]      psw,
  output logic [15:0]      pc,
  output logic [15:0]      sp_active
);
  localparam int PAD = WORD_W - VEC_W;

  seq_st_t           st;
  logic [15:0]       psw_q, pc_q, held_psw, held_pc;
  logic [VEC_W-1:0]  vec_q, vec_sel;
  logic              take_entry, take_rtt, step_dn, step_up;

  trap_cause_arb #(.VEC_W(VEC_W), .SVC_VEC(SVC_VEC), .ILL_VEC(ILL_VEC)) u_arb (
    .boundary(instr_boundary), .idle(st == S_IDLE),
    .svc_req(svc_req), .ill_req(ill_req), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vector(irq_vector), .rtt_req(rtt_req),
    .cur_pri(psw_q[7:5]), .take_entry(take_entry), .take_rtt(take_rtt),
    .irq_ack(irq_ack), .vec_sel(vec_sel));

  trap_sp_bank #(.KSP_INIT(KSP_INIT), .USP_INIT(USP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_n), .sel_user(uses_user_sp(psw_q)),
    .step_dn(step_dn), .step_up(step_up), .sp_act(sp_active));

  // Memory port and stack stepping, decoded from the state.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    step_dn   = 1'b0;
    step_up   = 1'b0;
    unique case (st)
      S_VPC:      begin mem_req = 1'b1; mem_addr = {{PAD{1'b0}}, vec_q}; end
      S_VPSW:     begin mem_req = 1'b1; mem_addr = {{PAD{1'b0}}, vec_q + VEC_W'(2)}; end
      S_PUSH_PSW: begin mem_req = 1'b1; mem_we = 1'b1; step_dn = 1'b1;
                        mem_addr = sp_active - 16'd2; mem_wdata = held_psw; end
      S_PUSH_PC:  begin mem_req = 1'b1; mem_we = 1'b1; step_dn = 1'b1;
                        mem_addr = sp_active - 16'd2; mem_wdata = held_pc; end
      S_POP_PC,
      S_POP_PSW:  begin mem_req = 1'b1; step_up = 1'b1; mem_addr = sp_active; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      psw_q    <= RESET_PSW;
      pc_q     <= RESET_PC;
      held_psw <= '0;
      held_pc  <= '0;
      vec_q    <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (take_entry) begin
            held_psw <= psw_q;
            held_pc  <= pc_q;
            vec_q    <= vec_sel;
            st       <= S_VPC;
          end else if (take_rtt) begin
            st <= S_POP_PC;
          end else if (psw_wr_en) begin
            psw_q <= psw_wr_val;
          end
        end
        S_VPC:      st <= S_VPSW;
        S_VPSW:     begin pc_q <= mem_rdata; st <= S_LDPSW; end
        S_LDPSW:    begin psw_q <= with_prev(mem_rdata, held_psw[15:14]); st <= S_PUSH_PSW; end
        S_PUSH_PSW: st <= S_PUSH_PC;
        S_PUSH_PC:  st <= S_IDLE;
        S_POP_PC:   st <= S_POP_PSW;
        S_POP_PSW:  begin pc_q <= mem_rdata; st <= S_RLPSW; end
        S_RLPSW:    begin psw_q <= mem_rdata; st <= S_IDLE; end
        default:    st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign psw  = psw_q;
  assign pc   = pc_q;

  // R3: the pushed old current mode equals the new previous mode
  p_prev_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUSH_PSW) |-> psw_q[13:12] == mem_wdata[15:14]);

  // R5: every write lands just below the pointer of the mode now active
  p_push_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_active - 16'd2);

  // R9: status word frozen between vector fetch and end of the pushes
  p_psw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VPC || st == S_PUSH_PSW || st == S_PUSH_PC) |=> $stable(psw_q));

  // R6: an accepted interrupt fetches from its own slot next cycle
  p_ack_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (mem_req && !mem_we && mem_addr == {{PAD{1'b0}}, $past(irq_vector)}));

  // R7: a trap instruction wins over everything else
  p_svc_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_boundary && !busy && svc_req) |=> (mem_req && mem_addr == {{PAD{1'b0}}, SVC_VEC}));

  // R8: a return only reads
  p_return_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POP_PC || st == S_POP_PSW) |-> (mem_req && !mem_we));
endmodule

// File: tb/trap_entry_seq_tb.sv
`timescale 1ns/1ps
module trap_entry_seq_tb;
  localparam logic [15:0] RST_PSW = 16'o170000;
  localparam logic [15:0] RST_PC  = 16'o004000;
  localparam logic [15:0] KSP = 16'o000400;
  localparam logic [15:0] USP = 16'o000700;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_boundary = 0, svc_req = 0, ill_req = 0, irq_req = 0, rtt_req = 0, psw_wr_en = 0;
  logic [2:0] irq_level = 0;
  logic [7:0] irq_vector = 8'o100;
  logic [15:0] psw_wr_val = 0;
  logic mem_req, mem_we, irq_ack, busy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = 0, psw, pc, sp_active;
  logic [15:0] mem [256];
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  trap_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .instr_boundary(instr_boundary),
    .svc_req(svc_req), .ill_req(ill_req), .irq_req(irq_req),
    .irq_level(irq_level), .irq_vector(irq_vector), .rtt_req(rtt_req),
    .psw_wr_en(psw_wr_en), .psw_wr_val(psw_wr_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_ack(irq_ack),
    .busy(busy), .psw(psw), .pc(pc), .sp_active(sp_active));

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
    else        mem_rdata <= mem[mem_addr[8:1]];
  end

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem[a[8:1]];
  endfunction

  // expected status word after entry: vector word, previous field <- old current field
  function automatic logic [15:0] entry_psw(input logic [15:0] vw, input logic [15:0] old);
    return (vw & ~16'o030000) | ((old >> 2) & 16'o030000);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%o expected=%o", req, act, exp);
    end
  endtask

  int ncyc;
  logic ack_seen;

  // one boundary with the given requests; counts busy cycles afterwards
  task automatic step(input logic s, input logic il, input logic iq,
                      input logic [2:0] lv, input logic rt);
    @(negedge clk);
    svc_req = s; ill_req = il; irq_req = iq; irq_level = lv; rtt_req = rt;
    instr_boundary = 1;
    #0.5 ack_seen = irq_ack;
    @(negedge clk);
    instr_boundary = 0; svc_req = 0; ill_req = 0; irq_req = 0; rtt_req = 0;
    ncyc = 0;
    while (busy && ncyc < 50) begin ncyc++; @(negedge clk); end
  endtask

  task automatic set_psw(input logic [15:0] v);
    @(negedge clk); psw_wr_en = 1; psw_wr_val = v;
    @(negedge clk); psw_wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
    mem[8'o034 >> 1] = 16'o001000; mem[8'o036 >> 1] = 16'o000340;
    mem[8'o010 >> 1] = 16'o002000; mem[8'o012 >> 1] = 16'o000240;
    mem[8'o100 >> 1] = 16'o003000; mem[8'o102 >> 1] = 16'o000300;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 psw", psw, RST_PSW);
    check("R1 pc", pc, RST_PC);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 mem_req", {15'd0, mem_req}, 16'd0);
    check("R5 user sp at reset", sp_active, USP);

    // R2/R3/R4/R5/R10 trap from user mode
    step(1, 0, 0, 0, 0);
    check("R10 entry length", 16'(ncyc), 16'd5);
    check("R2 pc from 034", pc, 16'o001000);
    check("R3 psw from 036", psw, entry_psw(16'o000340, RST_PSW));
    check("R5 kernel sp after entry", sp_active, KSP - 16'd4);
    check("R4 saved psw", rd(KSP - 16'd2), RST_PSW);
    check("R4 saved pc", rd(KSP - 16'd4), RST_PC);

    // R8 return to user
    step(0, 0, 0, 0, 1);
    check("R10 return length", 16'(ncyc), 16'd3);
    check("R8 pc", pc, RST_PC);
    check("R8 psw", psw, RST_PSW);
    check("R8 user sp", sp_active, USP);

    // R7 all together: trap wins, no ack
    step(1, 1, 1, 3'd7, 1);
    check("R7 trap first pc", pc, 16'o001000);
    check("R7 no ack", {15'd0, ack_seen}, 16'd0);
    step(0, 0, 0, 0, 1);
    // R7 illegal beats interrupt
    step(0, 1, 1, 3'd7, 0);
    check("R7 illegal pc", pc, 16'o002000);
    check("R7 illegal psw", psw, entry_psw(16'o000240, RST_PSW));
    step(0, 0, 0, 0, 1);
    check("R8 back after illegal", sp_active, USP);

    // R6/R11 sweep: priority x level in kernel mode
    for (int p = 0; p < 8; p++) begin
      for (int l = 0; l < 8; l++) begin
        logic [15:0] sv;
        sv = 16'(p << 5);
        set_psw(sv);
        check("R11 psw write", psw, sv);
        step(0, 0, 1, 3'(l), 0);
        if (l > p) begin
          check("R6 ack", {15'd0, ack_seen}, 16'd1);
          check("R10 irq length", 16'(ncyc), 16'd5);
          check("R6 irq pc", pc, 16'o003000);
          check("R3 irq psw", psw, entry_psw(16'o000300, sv));
          check("R4 irq saved psw", rd(KSP - 16'd2), sv);
          check("R4 irq saved pc", rd(KSP - 16'd4), RST_PC);
          step(0, 0, 0, 0, 1);
          check("R8 irq return psw", psw, sv);
          check("R8 irq return sp", sp_active, KSP);
        end else begin
          check("R6 no ack", {15'd0, ack_seen}, 16'd0);
          check("R10 nothing started", 16'(ncyc), 16'd0);
          check("R6 pc unchanged", pc, RST_PC);
        end
      end
    end

    // R9 requests held high during a running entry are ignored
    set_psw(16'd0);
    @(negedge clk);
    svc_req = 1; instr_boundary = 1;
    @(negedge clk);
    svc_req = 0; irq_req = 1; irq_level = 3'd7; psw_wr_en = 1; psw_wr_val = 16'o177777;
    ncyc = 0;
    while (busy && ncyc < 50) begin ncyc++; @(negedge clk); end
    instr_boundary = 0; irq_req = 0; psw_wr_en = 0;
    @(negedge clk);
    check("R9 one entry only", 16'(ncyc), 16'd5);
    check("R9 still idle", {15'd0, busy}, 16'd0);
    check("R9 pc", pc, 16'o001000);
    check("R9 psw not overwritten", psw, 16'o000340);
    check("R9 single push pair", sp_active, KSP - 16'd4);
    step(0, 0, 0, 0, 1);
    check("R8 kernel return", psw, 16'd0);

    // R7 interrupt beats return
    step(0, 0, 1, 3'd4, 1);
    check("R7 irq over return", pc, 16'o003000);
    step(0, 0, 0, 0, 1);
    check("R8 final pc", pc, RST_PC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule